// File: doc/BRIEF.md
# Handshaked Parallel Output Port

This block is a memory-mapped output port that sits on a synchronous processor bus. It drives a byte to a printer-like peripheral, and it lets the processor read whether that peripheral can take another byte. The upper address bits go to a comparator against a base address parameter. The two lowest address bits pick an internal location.

Each bus access to the port's address starts a single-cycle response window. During that window the port raises its ready line to the bus. A write to the data location latches the byte onto the peripheral lines and raises a valid strobe. The strobe stays high until the peripheral signals idle. A read of the status location returns a bit that is set while no byte is pending.

Top module: `par_out_port`

## Requirements
- R1: While rst_ni is low, pdata_o is 0, valid_o is 0, slave_rdy_o is 0 and rdata_o is 0.
- R2: The port responds only when addr_i[ADDR_W-1:2] equals BASE_ADDR[ADDR_W-1:2]. Any other address leaves slave_rdy_o low and changes neither pdata_o nor valid_o.
- R3: The cycle after a clock edge that samples a matching address, slave_rdy_o is high for exactly one cycle, and the timing logic then returns to idle. If the match is still present, slave_rdy_o is high again one cycle later, so a held match gives a 1,0,1,0 pattern.
- R4: A write (rw_i = 0) to offset 0 (addr_i[1:0] = 0) during the response cycle loads wdata_i into pdata_o at the edge that ends the cycle, and sets valid_o.
- R5: A write to offset 0 while valid_o is already high replaces pdata_o with the new byte, and valid_o stays high.
- R6: When idle_i is high at a clock edge and no load happens at that edge, valid_o is cleared. When a load and idle_i coincide, the load wins and valid_o is 1.
- R7: A read (rw_i = 1) of offset 1 returns, during the response cycle, rdata_o bit 0 equal to the inverse of valid_o, with all other bits at 0.
- R8: Reads of offsets 0, 2 and 3 return 0. rdata_o is 0 whenever slave_rdy_o is low.
- R9: Writes to offsets 1, 2 and 3 leave pdata_o and valid_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Bus address |
| rw_i | input | 1 | 1 = read, 0 = write |
| wdata_i | input | DATA_W | Write data from the bus |
| rdata_o | output | DATA_W | Read data to the bus, zero outside a read response |
| slave_rdy_o | output | 1 | Ends the current bus transfer |
| pdata_o | output | DATA_W | Byte held for the peripheral |
| valid_o | output | 1 | A new byte is pending for the peripheral |
| idle_i | input | 1 | The peripheral has taken the byte and is idle |

## Verification
The bench builds the port with a 16-bit address, an 8-bit data path and the base address 16'hA5C0. With the narrow address, the bench can try near-miss addresses that differ in the highest decoded bit and in the lowest decoded bit (bit 2). The bench holds a match across several edges to show the response pattern. It also makes a load and an idle pulse meet at the same edge, and it resets the port while a byte is pending.

// File: rtl/par_out_pkg.sv
package par_out_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic {
    TS_IDLE = 1'b0,
    TS_RESP = 1'b1
  } tstate_e;

  localparam logic [SEL_W-1:0] OFF_DATA = 2'd0;
  localparam logic [SEL_W-1:0] OFF_STAT = 2'd1;
endpackage

// File: rtl/par_out_dec.sv
module par_out_dec
  import par_out_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [SEL_W-1:0]  sel_o
);
  localparam int unsigned TAG_W = ADDR_W - SEL_W;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:SEL_W];

  assign hit_o = (addr_i[ADDR_W-1:SEL_W] == BASE_TAG);
  assign sel_o = addr_i[SEL_W-1:0];
endmodule

// File: rtl/par_out_fsm.sv
module par_out_fsm
  import par_out_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic go_o
);
  tstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_IDLE: if (hit_i) state_d = TS_RESP;
      TS_RESP: state_d = TS_IDLE; // one cycle, match ignored
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TS_IDLE;
    else         state_q <= state_d;
  end

  assign go_o = (state_q == TS_RESP);
endmodule

// File: rtl/par_out_reg.sv
module par_out_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              idle_i,
  output logic [DATA_W-1:0] pdata_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (load_i) data_q <= wdata_i;
      // load has priority over the peripheral's idle pulse
      if (load_i)      valid_q <= 1'b1;
      else if (idle_i) valid_q <= 1'b0;
    end
  end

  assign pdata_o = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/par_out_rdmux.sv
module par_out_rdmux
  import par_out_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              rd_en_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              valid_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] stat_word;

  generate
    if (DATA_W > 1) begin : g_pad
      assign stat_word = {{(DATA_W-1){1'b0}}, ~valid_i};
    end else begin : g_nopad
      assign stat_word = ~valid_i;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (rd_en_i && sel_i == OFF_STAT) rdata_o = stat_word;
  end
endmodule

// File: rtl/par_out_port.sv
module par_out_port
  import par_out_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              slave_rdy_o,
  output logic [DATA_W-1:0] pdata_o,
  output logic              valid_o,
  input  logic              idle_i
);
  logic             hit;
  logic [SEL_W-1:0] sel;
  logic             go;
  logic             load;
  logic             rd_en;

  par_out_dec #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) i_dec (
    .addr_i(addr_i),
    .hit_o (hit),
    .sel_o (sel)
  );

  par_out_fsm i_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (hit),
    .go_o  (go)
  );

  assign load  = go & ~rw_i & (sel == OFF_DATA);
  assign rd_en = go & rw_i;

  par_out_reg #(
    .DATA_W(DATA_W)
  ) i_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .wdata_i(wdata_i),
    .idle_i (idle_i),
    .pdata_o(pdata_o),
    .valid_o(valid_o)
  );

  par_out_rdmux #(
    .DATA_W(DATA_W)
  ) i_rdmux (
    .rd_en_i(rd_en),
    .sel_i  (sel),
    .valid_i(valid_o),
    .rdata_o(rdata_o)
  );

  assign slave_rdy_o = go;
endmodule

// File: rtl/par_out_port_chk.sv
module par_out_port_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rw_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              slave_rdy_o,
  input logic [DATA_W-1:0] pdata_o,
  input logic              valid_o,
  input logic              idle_i
);
  logic addr_hit, wr_data;
  assign addr_hit = (addr_i[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
  assign wr_data  = slave_rdy_o && !rw_i && addr_i[1:0] == 2'd0;

  assert_rdy_from_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_rdy_o |-> $past(addr_hit));

  assert_rdy_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_rdy_o |=> !slave_rdy_o);

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> (valid_o && pdata_o == $past(wdata_i)));

  assert_idle_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && !wr_data) |=> !valid_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_data |=> $stable(pdata_o));

  assert_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_rdy_o && rw_i && addr_i[1:0] == 2'd1) |-> rdata_o == DATA_W'(!valid_o));

  assert_rdata_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slave_rdy_o && rw_i && addr_i[1:0] == 2'd1) |-> rdata_o == '0);
endmodule

bind par_out_port par_out_port_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .BASE_ADDR(BASE_ADDR)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .rw_i       (rw_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .slave_rdy_o(slave_rdy_o),
  .pdata_o    (pdata_o),
  .valid_o    (valid_o),
  .idle_i     (idle_i)
);

// File: tb/test_par_out_port.sv
module test_par_out_port;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam logic [ADDR_W-1:0] BASE = 16'hA5C0;
  localparam logic [ADDR_W-1:0] MISS = 16'h0000;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WDOG = 5000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = MISS;
  logic              rw_i = 1'b1;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              slave_rdy_o;
  logic [DATA_W-1:0] pdata_o;
  logic              valid_o;
  logic              idle_i = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  par_out_port #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BASE_ADDR(BASE)
  ) i_par_out_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .rw_i       (rw_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .slave_rdy_o(slave_rdy_o),
    .pdata_o    (pdata_o),
    .valid_o    (valid_o),
    .idle_i     (idle_i)
  );

  typedef struct packed {
    logic       rw;
    logic [1:0] off;
    logic [7:0] wd;
    logic [7:0] exp_rd;
    logic       exp_v;
    logic [7:0] exp_pd;
  } vec_t;

  // walked in order from reset: pdata 0, valid 0
  localparam vec_t VEC [8] = '{
    '{1'b1, 2'd1, 8'h00, 8'h01, 1'b0, 8'h00}, // R7 ready
    '{1'b0, 2'd0, 8'h3C, 8'h00, 1'b1, 8'h3C}, // R4 load
    '{1'b1, 2'd1, 8'h00, 8'h00, 1'b1, 8'h3C}, // R7 pending
    '{1'b0, 2'd0, 8'hA7, 8'h00, 1'b1, 8'hA7}, // R5 overwrite
    '{1'b0, 2'd1, 8'hFF, 8'h00, 1'b1, 8'hA7}, // R9 off1
    '{1'b0, 2'd2, 8'h11, 8'h00, 1'b1, 8'hA7}, // R9 off2
    '{1'b1, 2'd0, 8'h00, 8'h00, 1'b1, 8'hA7}, // R8 off0
    '{1'b1, 2'd3, 8'h00, 8'h00, 1'b1, 8'hA7}  // R8 off3
  };

  task automatic chk(input int act, input int exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // called just after a negedge; returns just after a negedge
  task automatic access(input logic rw, input logic [1:0] off, input logic [7:0] wd,
                        input logic idle_at_load, input logic [7:0] exp_rd,
                        input logic exp_v, input logic [7:0] exp_pd, input string req);
    addr_i  = BASE | ADDR_W'(off);
    rw_i    = rw;
    wdata_i = wd;
    @(posedge clk_i); @(negedge clk_i);
    chk(slave_rdy_o, 1, {req, " slave_rdy in response (R3)"});
    chk(rdata_o, exp_rd, {req, " rdata"});
    if (idle_at_load) idle_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    idle_i = 1'b0;
    addr_i = MISS;
    rw_i   = 1'b1;
    chk(slave_rdy_o, 0, {req, " slave_rdy after response (R3)"});
    chk(valid_o, exp_v, {req, " valid"});
    chk(pdata_o, exp_pd, {req, " pdata"});
  endtask

  initial begin
    repeat (WDOG) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 while in reset, address matching
    addr_i = BASE | 16'd1;
    @(negedge clk_i);
    chk(pdata_o, 0, "R1 pdata in reset");
    chk(valid_o, 0, "R1 valid in reset");
    chk(slave_rdy_o, 0, "R1 slave_rdy in reset");
    chk(rdata_o, 0, "R1 rdata in reset");
    addr_i = MISS;
    rst_ni = 1'b1;
    @(negedge clk_i);

    foreach (VEC[i]) begin
      access(VEC[i].rw, VEC[i].off, VEC[i].wd, 1'b0,
             VEC[i].exp_rd, VEC[i].exp_v, VEC[i].exp_pd, $sformatf("vec%0d", i));
    end

    // R6 idle pulse clears valid, status then ready
    idle_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    idle_i = 1'b0;
    chk(valid_o, 0, "R6 idle clears valid");
    chk(pdata_o, 8'hA7, "R6 pdata kept on idle");
    access(1'b1, 2'd1, 8'h00, 1'b0, 8'h01, 1'b0, 8'hA7, "R7 status after idle");

    // R6 load and idle at the same edge: load wins
    access(1'b0, 2'd0, 8'h5A, 1'b1, 8'h00, 1'b1, 8'h5A, "R6 load beats idle");

    // R8 rdata quiet outside response, status address presented
    addr_i = BASE | 16'd1;
    rw_i   = 1'b1;
    #1;
    chk(rdata_o, 0, "R8 rdata before response");
    @(posedge clk_i); @(negedge clk_i);
    chk(rdata_o, 0, "R8 status reads 0 while valid (R7)");
    // R3 held match: already had one response; next 1,0 ... sequence
    chk(slave_rdy_o, 1, "R3 held match cycle1");
    @(posedge clk_i); @(negedge clk_i);
    chk(slave_rdy_o, 0, "R3 held match cycle2");
    @(posedge clk_i); @(negedge clk_i);
    chk(slave_rdy_o, 1, "R3 held match cycle3");
    @(posedge clk_i); @(negedge clk_i);
    chk(slave_rdy_o, 0, "R3 held match cycle4");
    addr_i = MISS;
    @(negedge clk_i);

    // R2 near misses: top decoded bit and bit 2 flipped, write to data offset
    begin
      logic [ADDR_W-1:0] miss_a [2];
      miss_a[0] = BASE ^ 16'h8000;
      miss_a[1] = BASE ^ 16'h0004;
      for (int m = 0; m < 2; m++) begin
        addr_i  = miss_a[m];
        rw_i    = 1'b0;
        wdata_i = 8'hC3;
        for (int c = 0; c < 3; c++) begin
          @(posedge clk_i); @(negedge clk_i);
          chk(slave_rdy_o, 0, $sformatf("R2 miss%0d no response", m));
        end
        chk(pdata_o, 8'h5A, $sformatf("R2 miss%0d pdata kept", m));
        chk(valid_o, 1, $sformatf("R2 miss%0d valid kept", m));
      end
      addr_i = MISS;
      rw_i   = 1'b1;
    end

    // R1 asynchronous reset with a byte pending
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(pdata_o, 0, "R1 pdata after reset");
    chk(valid_o, 0, "R1 valid after reset");
    chk(slave_rdy_o, 0, "R1 slave_rdy after reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    access(1'b1, 2'd1, 8'h00, 1'b0, 8'h01, 1'b0, 8'h00, "R1 status after reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule